// File: doc/BRIEF.md
# Single-Cycle Shift Execution Unit

This block performs the shift group of a 32-bit RISC datapath. It takes the decoded opcode field, the source operand read from register rb, the 5-bit count field carried in the instruction, and the low five bits of register rc. On the next clock it presents the shifted word, flagged by a valid strobe, for the register-file write into ra. The unit handles four kinds of shift: logical right, arithmetic right, logical left and left rotate.

The count has one of two sources. A nonzero immediate field gives the shift distance directly. When the immediate field is zero, the distance comes from the low bits of the rc register value, which is the register-count form of the instruction. A distance of zero leaves the operand unchanged. Opcodes outside the shift group produce no valid result, and the unit keeps its last result.

Top module: `shift_exec_unit`

## Requirements
- R1: Opcode 26 shifts the operand right by the count and fills the vacated upper bits with zeros.
- R2: Opcode 27 shifts the operand right by the count and fills the vacated upper bits with copies of operand bit 31.
- R3: Opcode 28 shifts the operand left by the count and fills the vacated lower bits with zeros.
- R4: Opcode 29 rotates the operand left by the count. Bits that leave bit 31 re-enter at bit 0.
- R5: If `imm_cnt` is nonzero it is the count and `reg_cnt` has no effect. If `imm_cnt` is zero, `reg_cnt` is the count.
- R6: When the selected count is zero, all four shifts return the operand unchanged.
- R7: With any opcode other than 26 to 29, or with `in_valid` low, `out_valid` is low on the next cycle and `result` keeps its previous value.
- R8: A valid shift presented in one cycle appears on `result` with `out_valid` high after exactly one rising clock edge. Back-to-back inputs give back-to-back outputs.
- R9: While `rst` is high at a rising edge, `out_valid` goes low and `result` goes to zero.
- R10: The instruction word 0xE1C60004, split into its opcode field (bits 31..27) and its count field (bits 4..0), drives a left shift by 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation request this cycle |
| op_code | input | 5 | Instruction opcode field |
| imm_cnt | input | 5 | Immediate count field of the instruction |
| src_val | input | 32 | Operand value from register rb |
| reg_cnt | input | 5 | Low bits of register rc, used as the count when `imm_cnt` is zero |
| out_valid | output | 1 | Result valid, one cycle after the request |
| result | output | 32 | Shifted word for register ra |

## Verification
The hardest case to reach from the ports is the one where both count sources are zero. Only then does the shift network pass the operand through for every opcode. A nonzero register count alone does not reach it, because the immediate field overrides it only when the immediate is nonzero. The stimulus therefore pairs a zero immediate with a zero register count and runs it through all four opcodes. Separate items pair a nonzero immediate with a different nonzero register count, which shows that the immediate wins. The bench predicts every output with its own shift model and checks the held result after rejected opcodes and idle cycles.

// File: rtl/shu_pkg.sv
package shu_pkg;
  localparam int OPC_W = 5;

  localparam logic [OPC_W-1:0] OPC_SHR  = 5'd26;
  localparam logic [OPC_W-1:0] OPC_SHRA = 5'd27;
  localparam logic [OPC_W-1:0] OPC_SHL  = 5'd28;
  localparam logic [OPC_W-1:0] OPC_SHC  = 5'd29;

  typedef enum logic [1:0] {
    SK_RIGHT_LOG = 2'd0,
    SK_RIGHT_ARI = 2'd1,
    SK_LEFT_LOG  = 2'd2,
    SK_LEFT_ROT  = 2'd3
  } shift_kind_e;
endpackage

// File: rtl/shu_decode.sv
module shu_decode
  import shu_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic [OPC_W-1:0] op_code,
  input  logic [CNT_W-1:0] imm_cnt,
  input  logic [CNT_W-1:0] reg_cnt,
  output logic             is_shift,
  output shift_kind_e      kind,
  output logic [CNT_W-1:0] count
);
  always_comb begin
    is_shift = 1'b1;
    kind     = SK_RIGHT_LOG;
    unique case (op_code)
      OPC_SHR:  kind = SK_RIGHT_LOG;
      OPC_SHRA: kind = SK_RIGHT_ARI;
      OPC_SHL:  kind = SK_LEFT_LOG;
      OPC_SHC:  kind = SK_LEFT_ROT;
      default:  is_shift = 1'b0;
    endcase
  end

  // A zero immediate field selects the register-count form.
  assign count = (imm_cnt != '0) ? imm_cnt : reg_cnt;
endmodule

// File: rtl/shu_mirror.sv
module shu_mirror #(
  parameter int W = 32
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[W-1-i];
  end
endmodule

// File: rtl/shu_stage.sv
module shu_stage #(
  parameter int W   = 32,
  parameter int AMT = 1
) (
  input  logic         en,
  input  logic         rot,
  input  logic         fill,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] moved;

  always_comb begin
    if (rot) moved = {din[W-AMT-1:0], din[W-1:W-AMT]};
    else     moved = {din[W-AMT-1:0], {AMT{fill}}};
  end

  assign dout = en ? moved : din;
endmodule

// File: rtl/shu_barrel.sv
module shu_barrel
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 5
) (
  input  logic [DATA_W-1:0] din,
  input  logic [CNT_W-1:0]  count,
  input  shift_kind_e       kind,
  output logic [DATA_W-1:0] dout
);
  logic              go_right;
  logic              rot;
  logic              fill;
  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;
  logic [DATA_W-1:0] lvl [CNT_W+1];

  assign go_right = (kind == SK_RIGHT_LOG) || (kind == SK_RIGHT_ARI);
  assign rot      = (kind == SK_LEFT_ROT);
  assign fill     = (kind == SK_RIGHT_ARI) ? din[DATA_W-1] : 1'b0;

  shu_mirror #(.W(DATA_W)) u_mir_in (.din(din), .dout(rev_in));

  assign lvl[0] = go_right ? rev_in : din;

  for (genvar i = 0; i < CNT_W; i++) begin : g_stage
    shu_stage #(.W(DATA_W), .AMT(1 << i)) u_stage (
      .en  (count[i]),
      .rot (rot),
      .fill(fill),
      .din (lvl[i]),
      .dout(lvl[i+1])
    );
  end

  shu_mirror #(.W(DATA_W)) u_mir_out (.din(lvl[CNT_W]), .dout(rev_out));

  assign dout = go_right ? rev_out : lvl[CNT_W];
endmodule

// File: rtl/shift_exec_unit.sv
module shift_exec_unit
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OPC_W-1:0]  op_code,
  input  logic [CNT_W-1:0]  imm_cnt,
  input  logic [DATA_W-1:0] src_val,
  input  logic [CNT_W-1:0]  reg_cnt,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  logic              is_shift;
  shift_kind_e       kind;
  logic [CNT_W-1:0]  count;
  logic [DATA_W-1:0] shifted;

  shu_decode #(.CNT_W(CNT_W)) u_decode (
    .op_code (op_code),
    .imm_cnt (imm_cnt),
    .reg_cnt (reg_cnt),
    .is_shift(is_shift),
    .kind    (kind),
    .count   (count)
  );

  shu_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_barrel (
    .din  (src_val),
    .count(count),
    .kind (kind),
    .dout (shifted)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid && is_shift;
      if (in_valid && is_shift) result <= shifted;
    end
  end
endmodule

// File: rtl/shu_checker.sv
module shu_checker
  import shu_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int CNT_W = $clog2(DATA_W)
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OPC_W-1:0]  op_code,
  input logic [CNT_W-1:0]  imm_cnt,
  input logic [DATA_W-1:0] src_val,
  input logic [CNT_W-1:0]  reg_cnt,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  logic shift_req;
  logic zero_dist;

  assign shift_req = in_valid && (op_code >= OPC_SHR) && (op_code <= OPC_SHC);
  assign zero_dist = (imm_cnt == '0) && (reg_cnt == '0);

  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (out_valid == $past(shift_req))); // R8

  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !out_valid) |-> (result == $past(result))); // R7

  AST_SHR_TOP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_code == OPC_SHR) && !$past(zero_dist)) |-> !result[DATA_W-1]); // R1

  AST_SHRA_SIGN: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_code == OPC_SHRA)) |-> (result[DATA_W-1] == $past(src_val[DATA_W-1]))); // R2

  AST_SHL_LSB_ZERO: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_code == OPC_SHL) && !$past(zero_dist)) |-> !result[0]); // R3

  AST_ROT_POPCOUNT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(op_code == OPC_SHC)) |-> ($countones(result) == $past($countones(src_val)))); // R4

  AST_ZERO_PASS: assert property (@(posedge clk) disable iff (rst)
    (out_valid && $past(zero_dist)) |-> (result == $past(src_val))); // R6
endmodule

bind shift_exec_unit shu_checker #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/shift_exec_unit_test.sv
module shift_exec_unit_test;
  localparam int CLK_P = 10;
  localparam int W = 32;

  typedef struct {
    logic         v;
    logic [W-1:0] r;
    string        tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [4:0]   op_code = '0;
  logic [4:0]   imm_cnt = '0;
  logic [W-1:0] src_val = '0;
  logic [4:0]   reg_cnt = '0;
  logic         out_valid;
  logic [W-1:0] result;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] last_res = '0;
  item_t sb[$];

  shift_exec_unit uut (.*);

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [W-1:0] model(input logic [4:0] op, input logic [W-1:0] v, input int n);
    logic [2*W-1:0] d;
    case (op)
      5'd26: return v >> n;
      5'd27: return $unsigned($signed(v) >>> n);
      5'd28: return v << n;
      default: begin
        d = {v, v} << n;
        return d[2*W-1:W];
      end
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send(input logic vld, input logic [4:0] op, input logic [4:0] imm,
                      input logic [W-1:0] val, input logic [4:0] rc, input string tag);
    item_t it;
    int n;
    @(negedge clk);
    in_valid = vld; op_code = op; imm_cnt = imm; src_val = val; reg_cnt = rc;
    n = (imm != 0) ? int'(imm) : int'(rc);
    it.v = vld && (op >= 5'd26) && (op <= 5'd29);
    if (it.v) last_res = model(op, val, n);
    it.r = last_res;
    it.tag = tag;
    sb.push_back(it);
  endtask

  // monitor: pops one expected item per clock edge after it was driven
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #(CLK_P/4);
      if (sb.size() != 0) begin
        it = sb.pop_front();
        check({it.tag, " valid"}, {{(W-1){1'b0}}, out_valid}, {{(W-1){1'b0}}, it.v});
        check({it.tag, " result"}, result, it.r);
      end
    end
  end

  initial begin
    #(CLK_P * 200000);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] word;
    repeat (3) @(negedge clk);
    check("R9 reset valid", {{(W-1){1'b0}}, out_valid}, '0);
    check("R9 reset result", result, '0);
    @(negedge clk);
    rst = 1'b0;

    send(1, 5'd26, 5'd1,  32'h8000_0001, 5'd0, "R1 shr 1");
    send(1, 5'd26, 5'd31, 32'h8000_0001, 5'd0, "R1 shr 31");
    send(1, 5'd26, 5'd4,  32'hF0F0_F0F0, 5'd9, "R1 shr 4");
    send(1, 5'd27, 5'd4,  32'h8000_0010, 5'd0, "R2 shra neg");
    send(1, 5'd27, 5'd8,  32'h7FFF_0000, 5'd0, "R2 shra pos");
    send(1, 5'd27, 5'd31, 32'h8000_0000, 5'd0, "R2 shra 31");
    send(1, 5'd28, 5'd31, 32'h0000_0001, 5'd0, "R3 shl 31");
    send(1, 5'd28, 5'd8,  32'h1234_5678, 5'd0, "R3 shl 8");
    send(1, 5'd29, 5'd1,  32'h8000_0001, 5'd0, "R4 shc 1");
    send(1, 5'd29, 5'd16, 32'h1234_5678, 5'd0, "R4 shc 16");
    send(1, 5'd29, 5'd31, 32'hC000_0003, 5'd0, "R4 shc 31");
    send(1, 5'd28, 5'd0,  32'h0000_00FF, 5'd12, "R5 reg count shl");
    send(1, 5'd26, 5'd3,  32'hFF00_0000, 5'd20, "R5 imm wins");
    send(1, 5'd29, 5'd0,  32'h8765_4321, 5'd7,  "R5 reg count shc");
    send(1, 5'd27, 5'd0,  32'h8000_0000, 5'd17, "R5 reg count shra");
    send(1, 5'd26, 5'd0,  32'h8000_00A5, 5'd0, "R6 pass shr");
    send(1, 5'd27, 5'd0,  32'h8000_00A5, 5'd0, "R6 pass shra");
    send(1, 5'd28, 5'd0,  32'h8000_00A5, 5'd0, "R6 pass shl");
    send(1, 5'd29, 5'd0,  32'h8000_00A5, 5'd0, "R6 pass shc");
    send(1, 5'd12, 5'd4,  32'hDEAD_BEEF, 5'd1, "R7 opcode 12");
    send(1, 5'd0,  5'd4,  32'hDEAD_BEEF, 5'd1, "R7 opcode 0");
    send(1, 5'd31, 5'd4,  32'hDEAD_BEEF, 5'd1, "R7 opcode 31");
    send(1, 5'd25, 5'd4,  32'hDEAD_BEEF, 5'd1, "R7 opcode 25");
    send(1, 5'd30, 5'd4,  32'hDEAD_BEEF, 5'd1, "R7 opcode 30");
    send(0, 5'd28, 5'd4,  32'hDEAD_BEEF, 5'd1, "R7 idle shift");
    word = 32'hE1C6_0004;
    send(1, word[31:27], word[4:0], 32'h0000_0ABC, 5'd0, "R10 word shl 4");
    for (int k = 0; k < 8; k++) begin
      send(1, 5'(26 + (k % 4)), 5'(k * 3 + 1), 32'h9E37_79B9 ^ (32'h0101_0101 * k), 5'(k), "R8 stream");
    end
    send(0, 5'd0, 5'd0, '0, 5'd0, "R8 drain");
    @(negedge clk);
    in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule